// File: doc/BRIEF.md
# Capture/compare programmable timer

This block is a timer peripheral built around a free-running up-counter. It has one input-capture channel, one output-compare channel and overflow detection. The counter advances on every clock and wraps from its all-ones value to zero. Each wrap raises an overflow flag. The capture channel snapshots the counter when a chosen edge appears. That edge can come from an external capture pin or from an internal comparator flag input. Both inputs are synchronized, and an edge on either one triggers a capture. The compare channel watches for equality between the counter and a compare register. On a match it latches a programmable level, and that level drives an output pin. The pin shows the level only while it is configured as an output.

Software uses a small register bus with a one-cycle write strobe and a combinational read. Status flags are cleared by writing ones to them. The interrupt request is the OR of each flag gated by its own enable. Each capture source has its own edge watcher, a two-state machine with the states EW_LOW and EW_HIGH. The transition EW_LOW to EW_HIGH is the rising transition and reports a hit when the edge-select bit is 1. The transition EW_HIGH to EW_LOW is the falling transition and reports a hit when the edge-select bit is 0. In every other case the state is held and no hit is reported. Reset places each watcher in EW_LOW.

Top module: `cap_cmp_timer`

Register map (bus_addr): 0 = control, 1 = status, 2 = counter (read only), 3 = capture (read only), 4 = compare. Control bits: bit0 overflow interrupt enable, bit1 capture interrupt enable, bit2 compare interrupt enable, bit3 edge select (1 rising, 0 falling), bit4 output level, bit5 compare pin output enable. Status bits: bit0 overflow, bit1 capture, bit2 compare.

## Requirements
- R1: The counter reads 0 during and right after reset and increases by one on every clock edge out of reset. It wraps from all ones to 0, so at any time it reads the number of edges since reset modulo 2^CNT_W.
- R2: The clock edge that moves the counter from all ones to 0 sets status bit0 (overflow).
- R3: The capture register reads 0 after reset. On a selected edge of a capture source, it loads the counter value and status bit1 is set. A source that changes just after a clock edge, at which the counter reads C, is captured as C+2.
- R4: Control bit3 chooses the capture edge: 1 for low-to-high, 0 for high-to-low. A transition in the opposite direction leaves both the capture register and status bit1 unchanged.
- R5: Reset leaves control bit3 at whatever value it held before the reset. Reset clears every other control bit to 0.
- R6: The compare register resets to all ones. On the clock edge at which the counter equals the compare register, status bit2 is set and the output latch takes the value of control bit4.
- R7: cmp_pin equals the output latch while control bit5 is 1 and reads 0 while bit5 is 0. cmp_pin_oe mirrors bit5. The latch resets to 0, and between compare matches cmp_pin changes only when bit5 changes.
- R8: Writing the status register clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. If a flag's setting event occurs on the same edge as its clear, the flag stays set.
- R9: irq is 1 exactly when some status bit i and control bit i are both 1, for i in 0..2.
- R10: The capture pin and the comparator flag input are independent trigger sources. A selected edge on either one alone performs the capture described in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from bus_addr |
| cap_pin | input | 1 | External capture input, asynchronous |
| cmpf_in | input | 1 | Internal comparator flag used as a capture source, asynchronous |
| cmp_pin | output | 1 | Compare output level |
| cmp_pin_oe | output | 1 | Compare pin configured as output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W = 8. With that width the counter wraps every 256 cycles, so several complete wraps and every overflow point can be observed directly. It also allows an exhaustive sweep: every one of the 256 compare values is programmed in turn, with the output level alternating, and the flag and pin are checked on both sides of each match. Capture is exercised from both sources, in both edge modes, at many counter phases, and the expected values come from a bench-side cycle count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_COUNT = 3'd2,
        A_CAPT  = 3'd3,
        A_CMPR  = 3'd4
    } reg_addr_e;

    localparam int unsigned C_OVF_IE = 0;
    localparam int unsigned C_CAP_IE = 1;
    localparam int unsigned C_CMP_IE = 2;
    localparam int unsigned C_EDGE   = 3;
    localparam int unsigned C_LEVEL  = 4;
    localparam int unsigned C_OE     = 5;
    localparam int unsigned C_W      = 6;

    localparam int unsigned F_OVF   = 0;
    localparam int unsigned F_CAP   = 1;
    localparam int unsigned F_CMP   = 2;
    localparam int unsigned N_FLAGS = 3;

    localparam int unsigned N_SRC = 2;

    typedef enum logic {
        EW_LOW  = 1'b0,
        EW_HIGH = 1'b1
    } edge_state_e;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    generate
        if (STAGES < 2) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= d;
            end
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise_sel,
    output logic hit
);

    edge_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= EW_LOW;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            EW_LOW:  if (lvl)  st_nx = EW_HIGH;
            EW_HIGH: if (!lvl) st_nx = EW_LOW;
            default: st_nx = EW_LOW;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        unique case (st)
            EW_LOW:  hit = lvl & rise_sel;
            EW_HIGH: hit = ~lvl & ~rise_sel;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             cap_pin,
    input  logic             cmpf_in,
    output logic             cmp_pin,
    output logic             cmp_pin_oe,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   cap_reg;
    logic [CNT_W-1:0]   cmp_reg;
    logic [N_FLAGS-1:0] ctrl_en;
    logic               edge_rise;
    logic               out_level;
    logic               out_oe;
    logic               cmp_latch;
    logic [N_FLAGS-1:0] flags;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_clr;
    logic [N_SRC-1:0]   src_raw;
    logic [N_SRC-1:0]   src_sync;
    logic [N_SRC-1:0]   src_hit;
    logic               cap_evt;
    logic               cnt_wrap;
    logic               cmp_match;
    logic               wr_ctrl;
    logic               wr_stat;
    logic               wr_cmpr;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_cmpr = bus_wr && (bus_addr == A_CMPR);

    // free-running counter
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CNT_ONE;
    end

    assign cnt_wrap  = (count == CNT_MAX);
    assign cmp_match = (count == cmp_reg);

    // control register, edge select held outside reset
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= '0;
            out_level <= 1'b0;
            out_oe    <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en   <= bus_wdata[N_FLAGS-1:0];
            out_level <= bus_wdata[C_LEVEL];
            out_oe    <= bus_wdata[C_OE];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ctrl) edge_rise <= bus_wdata[C_EDGE];
    end

    always_ff @(posedge clk) begin
        if (rst)          cmp_reg <= CNT_MAX;
        else if (wr_cmpr) cmp_reg <= bus_wdata;
    end

    // capture sources: synchronize, watch edges, merge
    assign src_raw = {cmpf_in, cap_pin};

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (src_raw[s]),
                .q   (src_sync[s])
            );
            tmr_edge_fsm u_edge (
                .clk      (clk),
                .rst      (rst),
                .lvl      (src_sync[s]),
                .rise_sel (edge_rise),
                .hit      (src_hit[s])
            );
        end
    endgenerate

    assign cap_evt = |src_hit;

    always_ff @(posedge clk) begin
        if (rst)          cap_reg <= '0;
        else if (cap_evt) cap_reg <= count;
    end

    // compare output latch
    always_ff @(posedge clk) begin
        if (rst)            cmp_latch <= 1'b0;
        else if (cmp_match) cmp_latch <= out_level;
    end

    assign cmp_pin    = out_oe & cmp_latch;
    assign cmp_pin_oe = out_oe;

    // status flags, set wins over write-one-to-clear
    always_comb begin
        flag_set        = '0;
        flag_set[F_OVF] = cnt_wrap;
        flag_set[F_CAP] = cap_evt;
        flag_set[F_CMP] = cmp_match;
    end

    assign flag_clr = wr_stat ? bus_wdata[N_FLAGS-1:0] : '0;

    generate
        for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
            tmr_flag u_flag (
                .clk (clk),
                .rst (rst),
                .set (flag_set[f]),
                .clr (flag_clr[f]),
                .q   (flags[f])
            );
        end
    endgenerate

    assign irq = |(flags & ctrl_en);

    // register read
    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            A_CTRL:  bus_rdata[C_W-1:0] = {out_oe, out_level, edge_rise, ctrl_en};
            A_STAT:  bus_rdata[N_FLAGS-1:0] = flags;
            A_COUNT: bus_rdata = count;
            A_CAPT:  bus_rdata = cap_reg;
            A_CMPR:  bus_rdata = cmp_reg;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [CNT_W-1:0]   count,
    input logic [CNT_W-1:0]   cmp_reg,
    input logic [CNT_W-1:0]   cap_reg,
    input logic               cap_evt,
    input logic [N_FLAGS-1:0] flags,
    input logic [N_FLAGS-1:0] flag_set,
    input logic               out_level,
    input logic               out_oe,
    input logic               cmp_latch,
    input logic               cmp_pin,
    input logic               bus_wr,
    input logic [2:0]         bus_addr,
    input logic [CNT_W-1:0]   bus_wdata
);

    localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (count == $past(count) + ONE_V));

    // R2
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(count) == MAX_V)) |-> (flags[F_OVF] && (count == '0)));

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cap_evt)) |-> ((cap_reg == $past(count)) && flags[F_CAP]));

    // R6
    cmp_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(count) == $past(cmp_reg)))
            |-> (flags[F_CMP] && (cmp_latch == $past(out_level))));

    // R7
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(count) != $past(cmp_reg)) && ($past(out_oe) == out_oe))
            |-> $stable(cmp_pin));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr) && ($past(bus_addr) == A_STAT)
            && $past(bus_wdata[F_OVF]) && !$past(flag_set[F_OVF])) |-> !flags[F_OVF]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & $past(flag_set)) == $past(flag_set)));

endmodule

bind cap_cmp_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .count     (count),
    .cmp_reg   (cmp_reg),
    .cap_reg   (cap_reg),
    .cap_evt   (cap_evt),
    .flags     (flags),
    .flag_set  (flag_set),
    .out_level (out_level),
    .out_oe    (out_oe),
    .cmp_latch (cmp_latch),
    .cmp_pin   (cmp_pin),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_cap_cmp_timer.sv
module sim_cap_cmp_timer;
    import tmr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int MOD        = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = 3'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         cap_pin = 1'b0;
    logic         cmpf_in = 1'b0;
    logic         cmp_pin;
    logic         cmp_pin_oe;
    logic         irq;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 1'b0;

    cap_cmp_timer #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cap_pin    (cap_pin),
        .cmpf_in    (cmpf_in),
        .cmp_pin    (cmp_pin),
        .cmp_pin_oe (cmp_pin_oe),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = W'(d);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_count(input int x);
        int c;
        do begin
            @(negedge clk);
            peek(A_COUNT, c);
        end while (c != x);
    endtask

    task automatic set_src(input int s, input logic val);
        if (s == 0) cap_pin = val;
        else        cmpf_in = val;
    endtask

    initial begin
        int v;
        int c;
        int exp_pin;
        int lvl;
        int saved;
        string rq;

        // reset state
        repeat (3) @(negedge clk);
        peek(A_COUNT, v); chk("R1 count at reset", v, 0);
        peek(A_STAT, v);  chk("R2 status at reset", v, 0);
        peek(A_CAPT, v);  chk("R3 capture at reset", v, 0);
        peek(A_CMPR, v);  chk("R6 compare at reset", v, MOD - 1);
        peek(A_CTRL, v);  chk("R5 ctrl at reset", v & 8'hF7, 0);
        chk("R7 pin at reset", int'(cmp_pin), 0);
        chk("R7 oe at reset", int'(cmp_pin_oe), 0);
        chk("R9 irq at reset", int'(irq), 0);
        rst = 1'b0;

        // R5: edge select survives reset, others clear
        wr(A_CTRL, 8'h3F);
        do_reset();
        peek(A_CTRL, v); chk("R5 edge kept at 1", v, 8'h08);
        wr(A_CTRL, 8'h37);
        do_reset();
        peek(A_CTRL, v); chk("R5 edge kept at 0", v, 8'h00);

        // R1 / R2: counter and overflow across two wraps
        for (int i = 0; i < 2 * MOD + 10; i++) begin
            @(negedge clk);
            peek(A_COUNT, v);
            chk("R1 count", v, cyc % MOD);
            peek(A_STAT, v);
            chk("R2 overflow flag", v & 1, (cyc >= MOD) ? 1 : 0);
        end

        // R8: write-one-to-clear and set priority
        wr(A_STAT, 0);
        peek(A_STAT, v); chk("R8 zero write keeps flag", v & 1, 1);
        wr(A_STAT, 1);
        peek(A_STAT, v); chk("R8 one write clears flag", v & 1, 0);
        wait_count(MOD - 1);
        bus_wr    = 1'b1;
        bus_addr  = A_STAT;
        bus_wdata = W'(1);
        @(negedge clk);
        bus_wr = 1'b0;
        peek(A_STAT, v); chk("R8 event wins over clear", v & 1, 1);

        // R6 / R7: exhaustive compare sweep
        wr(A_CTRL, 8'h20);
        exp_pin = 0;
        for (int cv = 0; cv < MOD; cv++) begin
            lvl = cv & 1;
            wait_count((cv + MOD / 2) % MOD);
            wr(A_CMPR, cv);
            wr(A_CTRL, 8'h20 | (lvl << 4));
            wr(A_STAT, 4);
            wait_count(cv);
            peek(A_STAT, v);
            chk("R6 compare flag before match", (v >> 2) & 1, 0);
            chk("R7 pin held before match", int'(cmp_pin), exp_pin);
            @(negedge clk);
            peek(A_STAT, v);
            chk("R6 compare flag on match", (v >> 2) & 1, 1);
            chk("R6 pin takes level", int'(cmp_pin), lvl);
            exp_pin = lvl;
        end

        // R7: output enable gating
        wr(A_CTRL, 8'h10);
        chk("R7 pin low when not output", int'(cmp_pin), 0);
        chk("R7 oe low", int'(cmp_pin_oe), 0);
        wr(A_CTRL, 8'h30);
        chk("R7 pin shows latch", int'(cmp_pin), exp_pin);
        chk("R7 oe high", int'(cmp_pin_oe), 1);

        // R3 / R4 / R10: rising mode
        wr(A_CTRL, 8'h08);
        wr(A_STAT, 2);
        for (int s = 0; s < N_SRC; s++) begin
            rq = (s == 0) ? "R3 pin" : "R10 comparator flag";
            for (int k = 0; k < 8; k++) begin
                repeat (k * 13 + 1) @(negedge clk);
                peek(A_COUNT, c);
                set_src(s, 1'b1);
                repeat (4) @(negedge clk);
                peek(A_CAPT, v); chk({rq, " rising capture value"}, v, (c + 2) % MOD);
                peek(A_STAT, v); chk({rq, " rising capture flag"}, (v >> 1) & 1, 1);
                wr(A_STAT, 2);
                peek(A_CAPT, saved);
                set_src(s, 1'b0);
                repeat (4) @(negedge clk);
                peek(A_STAT, v); chk("R4 falling ignored in rising mode flag", (v >> 1) & 1, 0);
                peek(A_CAPT, v); chk("R4 falling ignored in rising mode value", v, saved);
            end
        end

        // R3 / R4 / R10: falling mode
        wr(A_CTRL, 8'h00);
        wr(A_STAT, 2);
        for (int s = 0; s < N_SRC; s++) begin
            rq = (s == 0) ? "R3 pin" : "R10 comparator flag";
            for (int k = 0; k < 8; k++) begin
                peek(A_CAPT, saved);
                set_src(s, 1'b1);
                repeat (4) @(negedge clk);
                peek(A_STAT, v); chk("R4 rising ignored in falling mode flag", (v >> 1) & 1, 0);
                peek(A_CAPT, v); chk("R4 rising ignored in falling mode value", v, saved);
                repeat (k * 11 + 1) @(negedge clk);
                peek(A_COUNT, c);
                set_src(s, 1'b0);
                repeat (4) @(negedge clk);
                peek(A_CAPT, v); chk({rq, " falling capture value"}, v, (c + 2) % MOD);
                peek(A_STAT, v); chk({rq, " falling capture flag"}, (v >> 1) & 1, 1);
                wr(A_STAT, 2);
            end
        end

        // R9: interrupt gating over all enable masks
        for (int snap = 0; snap < 3; snap++) begin
            if (snap == 0) begin
                wr(A_STAT, 7);
            end else if (snap == 1) begin
                cap_pin = 1'b1;
                repeat (4) @(negedge clk);
                cap_pin = 1'b0;
                repeat (4) @(negedge clk);
            end else begin
                wait_count(1);
            end
            for (int en = 0; en < 8; en++) begin
                wr(A_CTRL, en);
                peek(A_STAT, v);
                chk("R9 irq", int'(irq), ((v & en & 7) != 0) ? 1 : 0);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule